// File: doc/BRIEF.md
# Boot Source Selection Controller

After reset this block decides where the processor boots from. It samples two strap pins and a one-bit option value at one fixed clock edge after reset is released, and maps them to a boot space: user flash, system memory or embedded SRAM. When the option value is cleared and the straps do not ask for SRAM, the block also checks the two flash banks before it decides. It reads the first word of each bank, which holds the initial stack pointer. A bank whose word points into internal SRAM is taken as holding a runnable image.

The probe uses a one-word read port: an address and a one-cycle request go out, and the block waits for a valid strobe with the data. The upper bank is always probed before the lower one. The block then raises a done flag and holds the final decision: the boot space code, whether to jump into a bank, which bank, and that bank's base address.

Top module: `boot_select_ctrl`

## Requirements
- R1: With the option bit at 1, the straps map as follows: pin0=0 gives user flash whatever pin1 is, pin0=1 with pin1=0 gives system memory, and pin0=1 with pin1=1 gives SRAM. The space codes are 2'b00 for user flash, 2'b01 for system memory and 2'b10 for SRAM. No flash read is issued in this case.
- R2: The straps and the option bit are captured on the fourth rising clock edge after reset is released. Values present at other edges, before or after that one, have no effect on the decision.
- R3: With the option bit at 0, pin0=1 and pin1=1 still give SRAM with no probe. Every other strap setting gives system memory and starts the bank probe.
- R4: The probe first reads address BANK_HI_BASE (default 0x0808_0000). If that word is valid, the result is a jump with jump_bank_o=1 and jump_addr_o=BANK_HI_BASE, and the lower bank is not read.
- R5: If the upper word is invalid, the probe next reads BANK_LO_BASE (default 0x0800_0000). If that word is valid, the result is a jump with jump_bank_o=0 and jump_addr_o=BANK_LO_BASE.
- R6: A stack-pointer word is valid only when SRAM_BASE <= word < SRAM_TOP (defaults 0x2000_0000 and 0x2001_0000; the top is exclusive). Any other value, including zero, is invalid.
- R7: If neither bank is valid, the result is system memory with jump_o=0, jump_bank_o=0 and jump_addr_o=0.
- R8: done_o stays low during reset and until the decision is final. Without a probe it rises on the fifth edge after release. With a probe it rises on the edge that takes the deciding read response. Once done_o is high, it and all decision outputs hold until the next reset.
- R9: Each read request is a single-cycle pulse with at most one read outstanding. The block waits for rd_valid_i before it moves on, and it issues no request once done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap0_i | input | 1 | Primary boot strap pin |
| strap1_i | input | 1 | Secondary boot strap pin |
| opt_nodual_i | input | 1 | Option bit; 0 enables the dual-bank probe |
| rd_addr_o | output | ADDR_W | Probe read address |
| rd_req_o | output | 1 | One-cycle read request |
| rd_data_i | input | ADDR_W | Read data (stack-pointer word) |
| rd_valid_i | input | 1 | Read data valid strobe |
| boot_space_o | output | 2 | Selected boot space code |
| jump_o | output | 1 | Jump into a flash bank |
| jump_bank_o | output | 1 | 1 = upper bank, 0 = lower bank |
| jump_addr_o | output | ADDR_W | Base address of the bank to jump to |
| done_o | output | 1 | Decision is final |

## Verification
The assertions assume a read port that answers each request with exactly one valid strobe, no earlier than the cycle after the request. They also assume that rd_valid_i stays low when no read is outstanding. The bench's flash model keeps to this. It answers every request after a per-case latency of one to three cycles and otherwise holds the strobe low. The straps are driven from the negative clock edge and are changed on purpose around the capture edge, so the bench can tell the capture edge apart from its neighbours.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [1:0] {
        SPACE_USER_FLASH = 2'b00,
        SPACE_SYSMEM     = 2'b01,
        SPACE_SRAM       = 2'b10
    } boot_space_e;

    typedef struct packed {
        logic pin0;
        logic pin1;
        logic opt;
    } strap_t;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_FINAL
    } probe_st_e;

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
    import boot_sel_pkg::*;
#(
    parameter int CAPTURE_EDGE = 4
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  strap_t straps_i,
    output strap_t straps_o,
    output logic   valid_o
);
    localparam int CNT_W = $clog2(CAPTURE_EDGE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CAPTURE_EDGE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        strap_t           val;
        logic             vld;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.vld) begin
            if (s_q.cnt == LAST) begin
                s_d.val = straps_i;
                s_d.vld = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign straps_o = s_q.val;
    assign valid_o  = s_q.vld;
endmodule

// File: rtl/boot_sp_check.sv
module boot_sp_check #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] SRAM_TOP  = 32'h2001_0000
) (
    input  logic [ADDR_W-1:0] word_i,
    output logic              ok_o
);
    always_comb begin
        ok_o = (word_i >= SRAM_BASE) && (word_i < SRAM_TOP);
    end
endmodule

// File: rtl/boot_probe_fsm.sv
module boot_probe_fsm
    import boot_sel_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] BANK_HI_BASE = 32'h0808_0000,
    parameter logic [ADDR_W-1:0] BANK_LO_BASE = 32'h0800_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  strap_t            straps_i,
    input  logic              straps_vld_i,
    input  logic              sp_ok_i,
    input  logic              rd_valid_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [1:0]        space_o,
    output logic              jump_o,
    output logic              jump_hi_o,
    output logic [ADDR_W-1:0] jump_addr_o,
    output logic              done_o
);
    typedef struct packed {
        probe_st_e         st;
        boot_space_e       space;
        logic              jump;
        logic              hi;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        rd_req_o  = 1'b0;
        rd_addr_o = '0;
        unique case (f_q.st)
            ST_ARM: begin
                if (straps_vld_i) begin
                    if (straps_i.pin0 && straps_i.pin1) begin
                        f_d.space = SPACE_SRAM;
                        f_d.done  = 1'b1;
                        f_d.st    = ST_FINAL;
                    end else if (!straps_i.opt) begin
                        f_d.space = SPACE_SYSMEM;
                        f_d.st    = ST_REQ_HI;
                    end else begin
                        f_d.space = straps_i.pin0 ? SPACE_SYSMEM : SPACE_USER_FLASH;
                        f_d.done  = 1'b1;
                        f_d.st    = ST_FINAL;
                    end
                end
            end
            ST_REQ_HI: begin
                rd_req_o  = 1'b1;
                rd_addr_o = BANK_HI_BASE;
                f_d.st    = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                rd_addr_o = BANK_HI_BASE;
                if (rd_valid_i) begin
                    if (sp_ok_i) begin
                        f_d.jump = 1'b1;
                        f_d.hi   = 1'b1;
                        f_d.addr = BANK_HI_BASE;
                        f_d.done = 1'b1;
                        f_d.st   = ST_FINAL;
                    end else begin
                        f_d.st   = ST_REQ_LO;
                    end
                end
            end
            ST_REQ_LO: begin
                rd_req_o  = 1'b1;
                rd_addr_o = BANK_LO_BASE;
                f_d.st    = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                rd_addr_o = BANK_LO_BASE;
                if (rd_valid_i) begin
                    if (sp_ok_i) begin
                        f_d.jump = 1'b1;
                        f_d.addr = BANK_LO_BASE;
                    end
                    f_d.done = 1'b1;
                    f_d.st   = ST_FINAL;
                end
            end
            ST_FINAL: begin
                f_d = f_q;
            end
            default: begin
                f_d = f_q;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q       <= '0;
            f_q.st    <= ST_ARM;
            f_q.space <= SPACE_USER_FLASH;
        end else begin
            f_q <= f_d;
        end
    end

    assign space_o     = f_q.space;
    assign jump_o      = f_q.jump;
    assign jump_hi_o   = f_q.hi;
    assign jump_addr_o = f_q.addr;
    assign done_o      = f_q.done;
endmodule

// File: rtl/boot_select_ctrl.sv
module boot_select_ctrl
    import boot_sel_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                CAPTURE_EDGE = 4,
    parameter logic [ADDR_W-1:0] SRAM_BASE    = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] SRAM_TOP     = 32'h2001_0000,
    parameter logic [ADDR_W-1:0] BANK_HI_BASE = 32'h0808_0000,
    parameter logic [ADDR_W-1:0] BANK_LO_BASE = 32'h0800_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strap0_i,
    input  logic              strap1_i,
    input  logic              opt_nodual_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_req_o,
    input  logic [ADDR_W-1:0] rd_data_i,
    input  logic              rd_valid_i,
    output logic [1:0]        boot_space_o,
    output logic              jump_o,
    output logic              jump_bank_o,
    output logic [ADDR_W-1:0] jump_addr_o,
    output logic              done_o
);
    strap_t straps_raw, straps_cap;
    logic   straps_vld;
    logic   sp_ok;

    assign straps_raw = '{pin0: strap0_i, pin1: strap1_i, opt: opt_nodual_i};

    boot_strap_sampler #(
        .CAPTURE_EDGE(CAPTURE_EDGE)
    ) u_sampler (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .straps_i(straps_raw),
        .straps_o(straps_cap),
        .valid_o (straps_vld)
    );

    boot_sp_check #(
        .ADDR_W   (ADDR_W),
        .SRAM_BASE(SRAM_BASE),
        .SRAM_TOP (SRAM_TOP)
    ) u_sp_check (
        .word_i(rd_data_i),
        .ok_o  (sp_ok)
    );

    boot_probe_fsm #(
        .ADDR_W      (ADDR_W),
        .BANK_HI_BASE(BANK_HI_BASE),
        .BANK_LO_BASE(BANK_LO_BASE)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .straps_i    (straps_cap),
        .straps_vld_i(straps_vld),
        .sp_ok_i     (sp_ok),
        .rd_valid_i  (rd_valid_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .space_o     (boot_space_o),
        .jump_o      (jump_o),
        .jump_hi_o   (jump_bank_o),
        .jump_addr_o (jump_addr_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/boot_select_ctrl_chk.sv
module boot_select_ctrl_chk #(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] BANK_HI_BASE = 32'h0808_0000,
    parameter logic [ADDR_W-1:0] BANK_LO_BASE = 32'h0800_0000
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [1:0]        boot_space_o,
    input logic              jump_o,
    input logic              jump_bank_o,
    input logic [ADDR_W-1:0] jump_addr_o,
    input logic              done_o
);
    p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o);

    p_no_req_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !rd_req_o);

    p_req_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |-> (rd_addr_o == BANK_HI_BASE || rd_addr_o == BANK_LO_BASE));

    p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (done_o && $stable(boot_space_o) && $stable(jump_o)
                    && $stable(jump_bank_o) && $stable(jump_addr_o)));

    p_jump_sysmem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && jump_o) |-> boot_space_o == 2'b01);

    p_jump_hi_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && jump_o && jump_bank_o) |-> jump_addr_o == BANK_HI_BASE);

    p_jump_lo_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && jump_o && !jump_bank_o) |-> jump_addr_o == BANK_LO_BASE);

    p_no_jump_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !jump_o) |-> (jump_addr_o == '0 && !jump_bank_o));
endmodule

bind boot_select_ctrl boot_select_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .BANK_HI_BASE(BANK_HI_BASE),
    .BANK_LO_BASE(BANK_LO_BASE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .boot_space_o(boot_space_o),
    .jump_o      (jump_o),
    .jump_bank_o (jump_bank_o),
    .jump_addr_o (jump_addr_o),
    .done_o      (done_o)
);

// File: tb/boot_select_ctrl_bench.sv
`timescale 1ns/1ps
module boot_select_ctrl_bench;
    localparam logic [31:0] HI = 32'h0808_0000;
    localparam logic [31:0] LO = 32'h0800_0000;
    localparam logic [31:0] SB = 32'h2000_0000;
    localparam logic [31:0] ST = 32'h2001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s0 = 1'b0, s1 = 1'b0, opt = 1'b1;
    logic [31:0] rd_addr, rd_data = '0, jaddr;
    logic        rd_req, rd_valid = 1'b0;
    logic [1:0]  space;
    logic        jump, jbank, done;

    int vectors = 0, misses = 0, cycles = 0;
    bit timed_out = 0;

    always #4 clk = ~clk;

    boot_select_ctrl u_boot_select_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .strap0_i(s0), .strap1_i(s1),
        .opt_nodual_i(opt), .rd_addr_o(rd_addr), .rd_req_o(rd_req),
        .rd_data_i(rd_data), .rd_valid_i(rd_valid), .boot_space_o(space),
        .jump_o(jump), .jump_bank_o(jbank), .jump_addr_o(jaddr), .done_o(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !timed_out) begin
            timed_out = 1;
            misses++;
            $display("FAIL watchdog R8: got no end, expected end before 100000 cycles");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic bit sp_ok(logic [31:0] w);
        return (w >= SB) && (w < ST);
    endfunction

    // pre: straps before edge 4, cap: at edge 4, post: afterwards; each {pin0,pin1,opt}
    task automatic run_case(string tag, logic [2:0] pre, logic [2:0] cap, logic [2:0] post,
                            logic [31:0] w_hi, logic [31:0] w_lo, int lat);
        int e = 0, ph = 0, cd = 0;
        logic [31:0] pend_addr = '0;
        logic [2:0] c = '0;
        logic [1:0] e_space = '0;
        logic e_done = 0, e_jump = 0, e_bank = 0, e_req;
        logic [31:0] e_addr = '0;
        int hold = 0;
        rst_n = 1'b0; rd_valid = 1'b0;
        {s0, s1, opt} = pre;
        repeat (3) begin
            @(negedge clk);
            chk({tag, " R8 reset done"}, 32'(done), 32'd0);
            chk({tag, " R9 reset req"}, 32'(rd_req), 32'd0);
        end
        rst_n = 1'b1;
        for (int it = 0; it < 60 && hold < 6; it++) begin
            // compare outputs this cycle
            e_req = (ph == 2 || ph == 4);
            chk({tag, " R8 done"}, 32'(done), 32'(e_done));
            chk({tag, " R9 req"}, 32'(rd_req), 32'(e_req));
            if (e_req) chk({tag, " R4/R5 addr"}, rd_addr, (ph == 2) ? HI : LO);
            if (e_done) begin
                chk({tag, " R1/R3 space"}, 32'(space), 32'(e_space));
                chk({tag, " R7 jump"}, 32'(jump), 32'(e_jump));
                chk({tag, " R4/R5 bank"}, 32'(jbank), 32'(e_bank));
                chk({tag, " R4/R5 jaddr"}, jaddr, e_addr);
                hold++;
            end
            // flash model
            rd_valid = 1'b0;
            if (rd_req) begin
                cd = lat; pend_addr = rd_addr;
            end else if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    rd_valid = 1'b1;
                    rd_data = (pend_addr == HI) ? w_hi : w_lo;
                end
            end
            // straps for the coming edge
            if (e < 3) {s0, s1, opt} = pre;
            else if (e == 3) {s0, s1, opt} = cap;
            else {s0, s1, opt} = post;
            // reference model step for the coming edge
            case (ph)
                0: begin e++; if (e == 4) begin c = cap; ph = 1; end end
                1: begin
                    if (c[2] && c[1]) begin e_space = 2'b10; e_done = 1; ph = 6; end
                    else if (!c[0]) begin e_space = 2'b01; ph = 2; end
                    else begin e_space = c[2] ? 2'b01 : 2'b00; e_done = 1; ph = 6; end
                end
                2: ph = 3;
                3: if (rd_valid) begin
                    if (sp_ok(rd_data)) begin
                        e_jump = 1; e_bank = 1; e_addr = HI; e_done = 1; ph = 6;
                    end else ph = 4;
                end
                4: ph = 5;
                5: if (rd_valid) begin
                    if (sp_ok(rd_data)) begin e_jump = 1; e_addr = LO; end
                    e_done = 1; ph = 6;
                end
                default: ;
            endcase
            @(negedge clk);
        end
        chk({tag, " R8 final done"}, 32'(done), 32'd1);
    endtask

    initial begin
        // R1: plain table, option bit set
        run_case("R1 flash", 3'b011, 3'b011, 3'b011, '0, '0, 1);
        run_case("R1 sysmem", 3'b101, 3'b101, 3'b101, '0, '0, 1);
        run_case("R1 sram", 3'b111, 3'b111, 3'b111, '0, '0, 1);
        // R2: only the fourth edge counts
        run_case("R2 edge4", 3'b111, 3'b011, 3'b101, '0, '0, 1);
        run_case("R2 edge4b", 3'b001, 3'b100, 3'b011, SB, SB, 2);
        // R3 R4: probe upper bank first, valid
        run_case("R4 hi", 3'b000, 3'b000, 3'b111, 32'h2000_4000, SB, 2);
        // R5: upper invalid, lower valid
        run_case("R5 lo", 3'b100, 3'b100, 3'b000, 32'h0, 32'h2000_0100, 3);
        // R6: range edges
        run_case("R6 base", 3'b010, 3'b010, 3'b010, SB, '0, 1);
        run_case("R6 top", 3'b000, 3'b000, 3'b000, ST, ST - 32'd4, 1);
        // R7: neither valid
        run_case("R7 none", 3'b000, 3'b000, 3'b000, ST, 32'h1FFF_FFFC, 2);
        // R3: SRAM wins even with option cleared
        run_case("R3 sram", 3'b110, 3'b110, 3'b000, SB, SB, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule